// File: doc/BRIEF.md
# Predicated Element Loop Sequencer

This block is a hardware element loop placed between instruction issue and the execution units. After a `start` pulse it holds the program counter and walks two element indices: a source step and a destination step. Each step runs from its stored value up towards the vector length. Each side has its own predicate mask, and either mask may be inverted on entry. A side whose element is masked off moves past that element alone. Two masks with different patterns therefore compress a sparse source into a dense destination, or expand a dense source into a sparse destination.

For every element where both sides are enabled, the block offers one operation request. The request carries a source register number (source base plus source step) and a destination register number (destination base plus destination step), and it is held under a valid/ready handshake. The two step counters form a state register that software can write while the block is idle and can read at any time. A loop that an interrupt stopped can therefore be resumed exactly where it left off. When either step reaches the vector length, both steps are cleared and a one-cycle completion pulse tells the front end to advance the program counter.

The controller has five states:
- `ST_IDLE` waits for `start`.
- `ST_SEEK` tests the current element on each side. It steps past disabled elements, goes to `ST_ISSUE` when both sides are enabled, goes to `ST_FINISH` at the end of the vector, and goes to `ST_HALT` on an interrupt request.
- `ST_ISSUE` holds the request until it is accepted. It then returns to `ST_SEEK`, or goes to `ST_HALT` if an interrupt request is pending.
- `ST_FINISH` pulses `loop_done` and returns to `ST_IDLE`.
- `ST_HALT` pulses `loop_halted` and returns to `ST_IDLE`.

Top module: `elem_loop_seq`

## Requirements
- R1: `pc_hold` is 0 after reset and in idle. It is 1 from the cycle after an accepted `start` until the loop ends or halts.
- R2: The enabled state of an element on each side is that side's mask bit, with bit i belonging to element i, XORed with that side's invert input.
- R3: A source element that is not enabled advances only the source step, so no request uses it (compress).
- R4: A destination element that is not enabled advances only the destination step, so no request writes it (expand).
- R5: Each request carries `op_src_reg = (src_base + src_step) mod 128` and `op_dst_reg = (dst_base + dst_step) mod 128`. Requests appear in ascending element order.
- R6: A pulse on `st_wr_en` in idle loads both steps, and the next loop starts from those values. A write while a loop runs is ignored.
- R7: When either step is greater than or equal to VL, the loop ends: both steps become 0 and `loop_done` pulses for one cycle. A VL of 0, or a stored step already at or above VL, produces no request.
- R8: With VL=1 and all-ones masks, exactly one request is made with the two base registers, after which `loop_done` pulses (scalar identity).
- R9: An interrupt request lets the request in flight complete and leaves the steps at their values after it. `loop_halted` then pulses, with no `loop_done`.
- R10: `op_valid` and both register outputs stay unchanged until `op_ready`. Each request is accepted exactly once.
- R11: VL can be as large as 64, with masks 64 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a loop (accepted in idle) |
| vl | input | 7 | Vector length, clamped to 64 |
| src_mask | input | 64 | Source predicate mask |
| src_inv | input | 1 | Invert source mask |
| dst_mask | input | 64 | Destination predicate mask |
| dst_inv | input | 1 | Invert destination mask |
| src_base | input | 7 | Source base register |
| dst_base | input | 7 | Destination base register |
| irq | input | 1 | Interrupt request |
| st_wr_en | input | 1 | Write step state (idle only) |
| st_wr_src | input | 7 | Source step value to write |
| st_wr_dst | input | 7 | Destination step value to write |
| st_src_step | output | 7 | Current source step |
| st_dst_step | output | 7 | Current destination step |
| op_valid | output | 1 | Operation request valid |
| op_ready | input | 1 | Execution unit accepts request |
| op_src_reg | output | 7 | Source register number |
| op_dst_reg | output | 7 | Destination register number |
| pc_hold | output | 1 | Program counter frozen |
| loop_done | output | 1 | Loop finished; advance PC |
| loop_halted | output | 1 | Loop stopped by interrupt |

## Verification
The bench checks compress and expand patterns where the two indices drift apart. A design that advanced both steps together on a disabled element would send requests with the wrong register pairs. It also covers a full 64-element run whose register numbers wrap past 127, which catches a carry into an eighth bit or a missing modulo. It exercises resumption from written steps, a step write issued mid-loop, and VL=0 or a stored step beyond VL. A design that reset the steps at `start` would replay elements, and one that took writes while busy would skip them. Finally, it raises an interrupt while a request is stalled. A design that dropped the stalled request, pulsed `loop_done` instead of `loop_halted`, or lost the saved steps would show the wrong remainder when the loop is resumed.

// File: rtl/elem_loop_pkg.sv
package elem_loop_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK,
        ST_ISSUE,
        ST_FINISH,
        ST_HALT
    } seq_state_e;
endpackage

// File: rtl/elem_step_ctr.sv
module elem_step_ctr #(
    parameter int STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld,
    input  logic [STEP_W-1:0] ld_val,
    input  logic              inc,
    output logic [STEP_W-1:0] step
);
    always_ff @(posedge clk) begin
        if (!rst_n)   step <= '0;
        else if (clr) step <= '0;
        else if (ld)  step <= ld_val;
        else if (inc) step <= step + STEP_W'(1);
    end
endmodule

// File: rtl/elem_pred_sel.sv
module elem_pred_sel #(
    parameter int MAXVL  = 64,
    parameter int STEP_W = 7
) (
    input  logic [MAXVL-1:0]  mask,
    input  logic              inv,
    input  logic [STEP_W-1:0] step,
    input  logic [STEP_W-1:0] vl,
    output logic              at_end,
    output logic              enabled
);
    localparam int IDX_W = $clog2(MAXVL);

    always_comb begin
        at_end  = (step >= vl);
        enabled = !at_end && (mask[step[IDX_W-1:0]] ^ inv);
    end
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
    import elem_loop_pkg::*;
#(
    parameter int MAXVL  = 64,
    parameter int REG_W  = 7,
    parameter int STEP_W = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [STEP_W-1:0] vl,
    input  logic [MAXVL-1:0]  src_mask,
    input  logic              src_inv,
    input  logic [MAXVL-1:0]  dst_mask,
    input  logic              dst_inv,
    input  logic [REG_W-1:0]  src_base,
    input  logic [REG_W-1:0]  dst_base,
    input  logic              irq,
    input  logic              st_wr_en,
    input  logic [STEP_W-1:0] st_wr_src,
    input  logic [STEP_W-1:0] st_wr_dst,
    output logic [STEP_W-1:0] st_src_step,
    output logic [STEP_W-1:0] st_dst_step,
    output logic              op_valid,
    input  logic              op_ready,
    output logic [REG_W-1:0]  op_src_reg,
    output logic [REG_W-1:0]  op_dst_reg,
    output logic              pc_hold,
    output logic              loop_done,
    output logic              loop_halted
);
    localparam int SUM_W = (REG_W > STEP_W) ? REG_W : STEP_W;
    localparam logic [STEP_W-1:0] VL_CAP = STEP_W'(MAXVL);

    seq_state_e state, state_nx;

    logic [STEP_W-1:0] vl_q;
    logic [MAXVL-1:0]  smask_q, dmask_q;
    logic              sinv_q, dinv_q;
    logic [REG_W-1:0]  sbase_q, dbase_q;

    logic clr_steps, ld_steps, inc_src, inc_dst;
    logic src_end, dst_end, src_on, dst_on;

    // Loop context is captured when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q    <= '0;
            smask_q <= '0;
            dmask_q <= '0;
            sinv_q  <= 1'b0;
            dinv_q  <= 1'b0;
            sbase_q <= '0;
            dbase_q <= '0;
        end else if (state == ST_IDLE && start) begin
            vl_q    <= (vl > VL_CAP) ? VL_CAP : vl;
            smask_q <= src_mask;
            dmask_q <= dst_mask;
            sinv_q  <= src_inv;
            dinv_q  <= dst_inv;
            sbase_q <= src_base;
            dbase_q <= dst_base;
        end
    end

    elem_step_ctr #(.STEP_W(STEP_W)) u_src_ctr (
        .clk(clk), .rst_n(rst_n), .clr(clr_steps), .ld(ld_steps),
        .ld_val(st_wr_src), .inc(inc_src), .step(st_src_step)
    );

    elem_step_ctr #(.STEP_W(STEP_W)) u_dst_ctr (
        .clk(clk), .rst_n(rst_n), .clr(clr_steps), .ld(ld_steps),
        .ld_val(st_wr_dst), .inc(inc_dst), .step(st_dst_step)
    );

    elem_pred_sel #(.MAXVL(MAXVL), .STEP_W(STEP_W)) u_src_sel (
        .mask(smask_q), .inv(sinv_q), .step(st_src_step), .vl(vl_q),
        .at_end(src_end), .enabled(src_on)
    );

    elem_pred_sel #(.MAXVL(MAXVL), .STEP_W(STEP_W)) u_dst_sel (
        .mask(dmask_q), .inv(dinv_q), .step(st_dst_step), .vl(vl_q),
        .at_end(dst_end), .enabled(dst_on)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state and counter controls
    always_comb begin
        state_nx  = state;
        clr_steps = 1'b0;
        ld_steps  = 1'b0;
        inc_src   = 1'b0;
        inc_dst   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ld_steps = st_wr_en;
                if (start) state_nx = ST_SEEK;
            end
            ST_SEEK: begin
                if (src_end || dst_end) begin
                    clr_steps = 1'b1;
                    state_nx  = ST_FINISH;
                end else if (irq) begin
                    state_nx = ST_HALT;
                end else if (src_on && dst_on) begin
                    state_nx = ST_ISSUE;
                end else begin
                    inc_src = !src_on;
                    inc_dst = !dst_on;
                end
            end
            ST_ISSUE: begin
                if (op_ready) begin
                    inc_src  = 1'b1;
                    inc_dst  = 1'b1;
                    state_nx = irq ? ST_HALT : ST_SEEK;
                end
            end
            ST_FINISH: state_nx = ST_IDLE;
            ST_HALT:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    logic [SUM_W-1:0] src_sum, dst_sum;
    always_comb begin
        src_sum     = SUM_W'(sbase_q) + SUM_W'(st_src_step);
        dst_sum     = SUM_W'(dbase_q) + SUM_W'(st_dst_step);
        op_src_reg  = src_sum[REG_W-1:0];
        op_dst_reg  = dst_sum[REG_W-1:0];
        op_valid    = (state == ST_ISSUE);
        pc_hold     = (state == ST_SEEK) || (state == ST_ISSUE);
        loop_done   = (state == ST_FINISH);
        loop_halted = (state == ST_HALT);
    end
endmodule

// File: rtl/elem_loop_seq_chk.sv
module elem_loop_seq_chk #(
    parameter int REG_W  = 7,
    parameter int STEP_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_wr_en,
    input logic [STEP_W-1:0] st_src_step,
    input logic [STEP_W-1:0] st_dst_step,
    input logic              op_valid,
    input logic              op_ready,
    input logic [REG_W-1:0]  op_src_reg,
    input logic [REG_W-1:0]  op_dst_reg,
    input logic              pc_hold,
    input logic              loop_done,
    input logic              loop_halted
);
    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ready |=> op_valid && $stable(op_src_reg) && $stable(op_dst_reg));

    p_single_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready |=> !op_valid);

    p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done |-> st_src_step == '0 && st_dst_step == '0);

    p_end_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(loop_done && loop_halted));

    p_idle_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_hold && !st_wr_en |=> $stable(st_src_step) && $stable(st_dst_step));

    p_valid_in_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> pc_hold);
endmodule

bind elem_loop_seq elem_loop_seq_chk #(.REG_W(REG_W), .STEP_W(STEP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_wr_en(st_wr_en),
    .st_src_step(st_src_step), .st_dst_step(st_dst_step),
    .op_valid(op_valid), .op_ready(op_ready),
    .op_src_reg(op_src_reg), .op_dst_reg(op_dst_reg),
    .pc_hold(pc_hold), .loop_done(loop_done), .loop_halted(loop_halted)
);

// File: tb/sim_elem_loop_seq.sv
`timescale 1ns/1ps
module sim_elem_loop_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vl = '0;
    logic [63:0] src_mask = '0, dst_mask = '0;
    logic        src_inv = 1'b0, dst_inv = 1'b0;
    logic [6:0]  src_base = '0, dst_base = '0;
    logic        irq = 1'b0;
    logic        st_wr_en = 1'b0;
    logic [6:0]  st_wr_src = '0, st_wr_dst = '0;
    logic [6:0]  st_src_step, st_dst_step;
    logic        op_valid, op_ready;
    logic [6:0]  op_src_reg, op_dst_reg;
    logic        pc_hold, loop_done, loop_halted;

    int n_tests = 0;
    int n_fail  = 0;
    int rdy_mode = 0;
    string cur_tag = "R5";
    int exp_s[$];
    int exp_d[$];

    always #5 clk = ~clk;

    elem_loop_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
        .src_mask(src_mask), .src_inv(src_inv), .dst_mask(dst_mask), .dst_inv(dst_inv),
        .src_base(src_base), .dst_base(dst_base), .irq(irq),
        .st_wr_en(st_wr_en), .st_wr_src(st_wr_src), .st_wr_dst(st_wr_dst),
        .st_src_step(st_src_step), .st_dst_step(st_dst_step),
        .op_valid(op_valid), .op_ready(op_ready),
        .op_src_reg(op_src_reg), .op_dst_reg(op_dst_reg),
        .pc_hold(pc_hold), .loop_done(loop_done), .loop_halted(loop_halted)
    );

    // Ready pattern: 0 always high, 1 toggling, 2 held low
    logic tgl = 1'b0;
    initial op_ready = 1'b1;
    always @(posedge clk) begin
        #2;
        tgl = ~tgl;
        op_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? tgl : 1'b0;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected register pairs as requests are accepted
    always @(negedge clk) begin
        if (rst_n && op_valid && op_ready) begin
            if (exp_s.size() == 0) begin
                check(1'b0, {cur_tag, " unexpected request"}, op_src_reg, -1);
            end else begin
                int es, ed;
                es = exp_s.pop_front();
                ed = exp_d.pop_front();
                check(op_src_reg == 7'(es), {cur_tag, " src reg"}, op_src_reg, es);
                check(op_dst_reg == 7'(ed), {cur_tag, " dst reg"}, op_dst_reg, ed);
            end
        end
    end

    // Expected requests from the requirements: pushes up to max_ops pairs
    task automatic model(input int n, input logic [63:0] sm, input logic si,
                         input logic [63:0] dm, input logic di, input int sb, input int db,
                         input int s0, input int d0, input int max_ops,
                         output int s_out, output int d_out);
        int s = s0, d = d0, k = 0;
        while (s < n && d < n && k < max_ops) begin
            logic es, ed;
            es = sm[s] ^ si;
            ed = dm[d] ^ di;
            if (es && ed) begin
                exp_s.push_back((sb + s) % 128);
                exp_d.push_back((db + d) % 128);
                s++; d++; k++;
            end else begin
                if (!es) s++;
                if (!ed) d++;
            end
        end
        s_out = s;
        d_out = d;
    endtask

    task automatic write_steps(input int s, input int d);
        @(negedge clk);
        st_wr_en = 1'b1; st_wr_src = 7'(s); st_wr_dst = 7'(d);
        @(negedge clk);
        st_wr_en = 1'b0;
    endtask

    task automatic kick(input int n, input logic [63:0] sm, input logic si,
                        input logic [63:0] dm, input logic di, input int sb, input int db);
        @(negedge clk);
        vl = 7'(n); src_mask = sm; src_inv = si; dst_mask = dm; dst_inv = di;
        src_base = 7'(sb); dst_base = 7'(db);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(pc_hold == 1'b1, "R1 pc_hold after start", pc_hold, 1);
    endtask

    // Wait for the end of a loop: returns 1 for done, 2 for halted, 0 on timeout
    task automatic wait_end(output int kind);
        kind = 0;
        for (int i = 0; i < 3000; i++) begin
            if (loop_done) begin kind = 1; break; end
            if (loop_halted) begin kind = 2; break; end
            @(negedge clk);
        end
    endtask

    task automatic run(input string tag, input int n, input logic [63:0] sm, input logic si,
                       input logic [63:0] dm, input logic di, input int sb, input int db,
                       input int s0, input int d0);
        int se, de, kind;
        cur_tag = tag;
        model(n, sm, si, dm, di, sb, db, s0, d0, 1000, se, de);
        if (s0 != 0 || d0 != 0) write_steps(s0, d0);
        kick(n, sm, si, dm, di, sb, db);
        wait_end(kind);
        check(kind == 1, {tag, " loop_done R7"}, kind, 1);
        check(st_src_step == 0 && st_dst_step == 0, {tag, " steps cleared R7"},
              {st_src_step, st_dst_step}, 0);
        check(exp_s.size() == 0, {tag, " missing requests"}, exp_s.size(), 0);
        @(negedge clk);
        check(pc_hold == 1'b0 && loop_done == 1'b0, {tag, " R1 released, R7 one-cycle pulse"},
              {pc_hold, loop_done}, 0);
        exp_s.delete();
        exp_d.delete();
    endtask

    initial begin
        int se, de, kind;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pc_hold == 0 && op_valid == 0 && loop_done == 0 && loop_halted == 0,
              "R1 reset state", {pc_hold, op_valid, loop_done, loop_halted}, 0);
        check(st_src_step == 0 && st_dst_step == 0, "R6 reset steps",
              {st_src_step, st_dst_step}, 0);

        // R8 scalar identity
        run("R8 scalar", 1, '1, 1'b0, '1, 1'b0, 12, 40, 0, 0);
        // R3 compress: sparse source, dense destination
        run("R3 compress", 8, 64'hA5, 1'b0, '1, 1'b0, 0, 20, 0, 0);
        // R4 expand: dense source, sparse destination
        run("R4 expand", 10, '1, 1'b0, 64'h2D3, 1'b0, 30, 50, 0, 0);
        // R2 inverted masks on both sides
        run("R2 inverted", 12, 64'h0F0, 1'b1, 64'h333, 1'b1, 5, 70, 0, 0);
        // R11 full length with R5 wrap past 127
        rdy_mode = 1;
        run("R11 R5 vl64 wrap", 64, 64'hFFFF_0FF0_F3CF_FFFF, 1'b0, '1, 1'b0, 100, 90, 0, 0);
        // R10 backpressure with mixed masks
        run("R10 backpressure", 16, 64'h5A5A, 1'b0, 64'hF0F3, 1'b0, 3, 9, 0, 0);
        rdy_mode = 0;
        // R6 resume from written steps
        run("R6 resume", 10, '1, 1'b0, 64'h3B7, 1'b0, 0, 0, 2, 3);
        // R7 zero length and stored step past VL
        run("R7 vl0", 0, '1, 1'b0, '1, 1'b0, 0, 0, 0, 0);
        run("R7 step beyond vl", 3, '1, 1'b0, '1, 1'b0, 0, 0, 5, 0);

        // R6 write while busy is ignored
        cur_tag = "R6 busy write";
        model(8, '1, 1'b0, '1, 1'b0, 10, 20, 0, 0, 1000, se, de);
        rdy_mode = 2;
        kick(8, '1, 1'b0, '1, 1'b0, 10, 20);
        while (!op_valid) @(negedge clk);
        st_wr_en = 1'b1; st_wr_src = 7'd5; st_wr_dst = 7'd6;
        @(negedge clk);
        st_wr_en = 1'b0;
        check(st_src_step == 0 && st_dst_step == 0, "R6 busy write ignored",
              {st_src_step, st_dst_step}, 0);
        rdy_mode = 0;
        wait_end(kind);
        check(kind == 1 && exp_s.size() == 0, "R6 busy write full loop", exp_s.size(), 0);
        exp_s.delete(); exp_d.delete();
        @(negedge clk);

        // R9 interrupt during a stalled request, then resume
        cur_tag = "R9 irq";
        model(12, 64'hFFC, 1'b0, 64'hFF6, 1'b0, 7, 60, 0, 0, 1, se, de);
        rdy_mode = 2;
        kick(12, 64'hFFC, 1'b0, 64'hFF6, 1'b0, 7, 60);
        while (!op_valid) @(negedge clk);
        irq = 1'b1;
        rdy_mode = 0;
        wait_end(kind);
        irq = 1'b0;
        check(kind == 2, "R9 halted not done", kind, 2);
        check(exp_s.size() == 0, "R9 in-flight request completed", exp_s.size(), 0);
        check(st_src_step == 7'(se) && st_dst_step == 7'(de), "R9 steps saved",
              {st_src_step, st_dst_step}, {se[6:0], de[6:0]});
        @(negedge clk);
        check(pc_hold == 1'b0, "R9 pc not held after halt", pc_hold, 0);
        run("R9 R6 resume after irq", 12, 64'hFFC, 1'b0, 64'hFF6, 1'b0, 7, 60, se, de);
        // resumed run above starts from the saved steps (write repeats same values)

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule